// File: doc/BRIEF.md
# Serial switch register access master

This block lets a host read and write the registers of an external Ethernet switch controller. The controller is reached over three lines: a chip select, a slow serial clock and a single data line that both sides drive in turn. The host presents one request at a time: a read/write flag, a table select (configuration table or counter table), a register address and, for writes, 16 bits of data. The master then builds the serial frame, toggles the serial clock at a rate set by a system-cycle divider, and turns the data line around for reads. When the transaction ends it returns a 32-bit result together with a one-cycle done strobe.

Reads and writes use different frames. A read opens with a long run of ones while chip select stays low, then a short command. The master then releases the data line and clocks the reply in. A write is a shorter frame sent while chip select is high. Both kinds end with two extra clock pulses. When no transaction is running, every line is released through its own output enable, so other logic may share the pins.

Top module: `swreg_serial_master`

## Requirements
- R1: A read shifts out 46 bits, MSB first, sampled by the device on rising serial clock edges: 32 ones, then 0,1,1,0, then the table bit (0 = configuration, 1 = counter), then 0,0, then address bits 6 down to 0. Address bit 7 is not sent.
- R2: During a read, chip select (active high) is never asserted, while its output enable is on for the whole transaction.
- R3: After the read command the data-line enable goes low. The master issues 2 clocks, samples 32 reply bits MSB first (each bit present before its rising edge), then issues 2 more clocks: 82 rising edges per read, 36 of them with the data line released.
- R4: A write shifts out 27 bits, MSB first, all with chip select high: 1, then 0,1, then address bits 7..0, then data bits 15..0.
- R5: After a write's last bit, chip select falls while the clock is low. Exactly 2 more clock pulses follow (29 rising edges per write). Chip select changes only when the clock has been low for the previous cycle too.
- R6: The data line changes only while the clock is low, and it is stable for at least HALF_CYCLES system cycles before each rising edge.
- R7: Every clock level lasts at least HALF_CYCLES system cycles.
- R8: For a configuration-table read, the result is the first 16 reply bits when the address is odd and the last 16 bits when it is even, zero-extended to 32 bits.
- R9: For a counter-table read, the result is all 32 reply bits, with the first bit received in bit 31.
- R10: A write returns a result of zero.
- R11: busy is high from the cycle after a request is accepted until done. A request presented while busy is ignored and never starts a transaction.
- R12: done is a one-cycle pulse, with busy already low. result changes only when done is raised.
- R13: After reset, and from one cycle after done until the next request, all three output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe; accepted only when not busy |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqTable | input | 1 | Read table select: 0 configuration, 1 counter |
| reqAddr | input | 8 | Register address (reads send bits 6..0) |
| reqWdata | input | 16 | Write data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Read result, or zero after a write |
| csOut | output | 1 | Chip select level, active high |
| csOe | output | 1 | Chip select output enable |
| sclkOut | output | 1 | Serial clock level |
| sclkOe | output | 1 | Serial clock output enable |
| sdOut | output | 1 | Data line drive value |
| sdOe | output | 1 | Data line output enable |
| sdIn | input | 1 | Data line input value |

## Verification
The two hardest situations to reach from the ports are the alignment of the read reply after the turnaround and a second request arriving in the middle of a frame. The bench models the responding device. It counts rising clock edges while the data line is released and puts reply bit 31 on the line after the second such edge. A result that is off by one bit therefore shows up as a wrong word. For the second case, a conflicting read request is pulsed about ten clock levels into a write frame, and the captured frame, the number of done pulses and the quiet lines afterwards are all checked.

// File: rtl/swreg_pkg.sv
package swreg_pkg;
  // frame geometry
  localparam int RdPreambleBits = 32;
  localparam int RdCmdBits      = 46;
  localparam int WrCmdBits      = 27;
  localparam int RdDataBits     = 32;
  localparam int CfgRegBits     = 16;
  localparam int FrameBits      = RdCmdBits;
  localparam int IdxW           = $clog2(2 * RdCmdBits + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,     // outputs enabled, all low
    ST_CSON,      // chip select settles
    ST_SEND,      // command bits, low half then high half
    ST_POSTSEND,  // clock low after the last bit
    ST_TURN,      // data line released
    ST_PRECLK,    // two idle clocks before the reply
    ST_RECV,      // reply bits
    ST_POSTRECV,  // clock low after the reply
    ST_TRAIL      // low half, then two extra clocks
  } seqState_t;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic shiftIn;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/swreg_half_timer.sv
module swreg_half_timer #(
  parameter int unsigned HALF_CYCLES = 300
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic tick
);
  localparam int unsigned CntW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CntW-1:0] CntLast = CntW'(HALF_CYCLES - 1);

  logic [CntW-1:0] cnt;

  assign tick = run && (cnt == CntLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  generate
    if (HALF_CYCLES > 1) begin : g_multi
      // R7
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/swreg_dpath.sv
module swreg_dpath
  import swreg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   strobe,
  input  logic        reqWrite,
  input  logic        reqTable,
  input  logic [7:0]  reqAddr,
  input  logic [15:0] reqWdata,
  input  logic        sdIn,
  output logic        txBit,
  output logic [31:0] result
);
  logic [FrameBits-1:0]  frame;
  logic [FrameBits-1:0]  rdFrame;
  logic [FrameBits-1:0]  wrFrame;
  logic [RdDataBits-1:0] rxWord;
  logic [31:0]           picked;
  logic                  isWrite;
  logic                  isCounter;
  logic                  addrOdd;

  always_comb begin
    rdFrame = {{RdPreambleBits{1'b1}}, 4'b0110, reqTable, 2'b00, reqAddr[6:0]};
    wrFrame = {1'b1, 2'b01, reqAddr, reqWdata, {(FrameBits - WrCmdBits){1'b0}}};
  end

  assign txBit = frame[FrameBits-1];

  always_comb begin
    if (isWrite)        picked = '0;
    else if (isCounter) picked = rxWord;
    else if (addrOdd)   picked = {{(32 - CfgRegBits){1'b0}}, rxWord[RdDataBits-1 -: CfgRegBits]};
    else                picked = {{(32 - CfgRegBits){1'b0}}, rxWord[CfgRegBits-1:0]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame     <= '0;
      rxWord    <= '0;
      isWrite   <= 1'b0;
      isCounter <= 1'b0;
      addrOdd   <= 1'b0;
      result    <= '0;
    end else begin
      if (strobe.load) begin
        frame     <= reqWrite ? wrFrame : rdFrame;
        rxWord    <= '0;
        isWrite   <= reqWrite;
        isCounter <= reqTable;
        addrOdd   <= reqAddr[0];
      end
      if (strobe.shiftOut) frame <= {frame[FrameBits-2:0], 1'b0};
      if (strobe.shiftIn)  rxWord <= {rxWord[RdDataBits-2:0], sdIn};
      if (strobe.capture)  result <= picked;
    end
  end

  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(result));
endmodule

// File: rtl/swreg_ctrl.sv
module swreg_ctrl
  import swreg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      tick,
  input  logic      txBit,
  output logic      run,
  output dpStrobe_t strobe,
  output logic      busy,
  output logic      done,
  output logic      csOut,
  output logic      csOe,
  output logic      sclkOut,
  output logic      sclkOe,
  output logic      sdOut,
  output logic      sdOe
);
  seqState_t       state;
  seqState_t       nextState;
  logic [IdxW-1:0] halfIdx;
  logic [IdxW-1:0] stateLen;
  logic            wrMode;
  logic            lastHalf;
  logic            accept;
  logic            sclkNext, csNext, sdNext, sdOeNext, lineOeNext;

  assign busy   = (state != ST_IDLE);
  assign run    = busy;
  assign accept = reqValid && (state == ST_IDLE);

  always_comb begin
    case (state)
      ST_SEND:   stateLen = wrMode ? IdxW'(2 * WrCmdBits) : IdxW'(2 * RdCmdBits);
      ST_PRECLK: stateLen = IdxW'(4);
      ST_RECV:   stateLen = IdxW'(2 * RdDataBits);
      ST_TRAIL:  stateLen = IdxW'(5);
      default:   stateLen = IdxW'(1);
    endcase
    lastHalf = (halfIdx == stateLen - IdxW'(1));
  end

  always_comb begin
    case (state)
      ST_SETUP:    nextState = ST_CSON;
      ST_CSON:     nextState = ST_SEND;
      ST_SEND:     nextState = ST_POSTSEND;
      ST_POSTSEND: nextState = wrMode ? ST_TRAIL : ST_TURN;
      ST_TURN:     nextState = ST_PRECLK;
      ST_PRECLK:   nextState = ST_RECV;
      ST_RECV:     nextState = ST_POSTRECV;
      ST_POSTRECV: nextState = ST_TRAIL;
      default:     nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.load     = accept;
    strobe.shiftOut = tick && (state == ST_SEND) && halfIdx[0];
    strobe.shiftIn  = tick && (state == ST_RECV) && !halfIdx[0];
    strobe.capture  = tick && (state == ST_TRAIL) && lastHalf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      halfIdx <= '0;
      wrMode  <= 1'b0;
    end else if (accept) begin
      state   <= ST_SETUP;
      halfIdx <= '0;
      wrMode  <= reqWrite;
    end else if (tick) begin
      if (lastHalf) begin
        state   <= nextState;
        halfIdx <= '0;
      end else begin
        halfIdx <= halfIdx + 1'b1;
      end
    end
  end

  // pin levels, decoded from state and registered so the lines never glitch
  always_comb begin
    case (state)
      ST_SEND, ST_RECV, ST_TRAIL: sclkNext = halfIdx[0];
      ST_PRECLK:                  sclkNext = !halfIdx[0];
      default:                    sclkNext = 1'b0;
    endcase
    csNext     = wrMode && (state inside {ST_CSON, ST_SEND, ST_POSTSEND});
    sdOeNext   = (state inside {ST_SETUP, ST_CSON, ST_SEND, ST_POSTSEND})
                 || (wrMode && state == ST_TRAIL);
    sdNext     = (state == ST_SEND) && txBit;
    lineOeNext = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkOut <= 1'b0;
      csOut   <= 1'b0;
      sdOut   <= 1'b0;
      sdOe    <= 1'b0;
      csOe    <= 1'b0;
      sclkOe  <= 1'b0;
      done    <= 1'b0;
    end else begin
      sclkOut <= sclkNext;
      csOut   <= csNext;
      sdOut   <= sdNext;
      sdOe    <= sdOeNext;
      csOe    <= lineOeNext;
      sclkOe  <= lineOeNext;
      done    <= strobe.capture;
    end
  end

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R12
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R13
  idle_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> !(csOe || sclkOe || sdOe));
  // R6
  sd_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sdOe && !$stable(sdOut)) |-> !sclkOut);
  // R5
  cs_low_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(csOut) |-> (!sclkOut && !$past(sclkOut)));
  // R2
  rd_cs_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wrMode) |-> !csOut);
endmodule

// File: rtl/swreg_serial_master.sv
module swreg_serial_master
  import swreg_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 300
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqTable,
  input  logic [7:0]  reqAddr,
  input  logic [15:0] reqWdata,
  output logic        busy,
  output logic        done,
  output logic [31:0] result,
  output logic        csOut,
  output logic        csOe,
  output logic        sclkOut,
  output logic        sclkOe,
  output logic        sdOut,
  output logic        sdOe,
  input  logic        sdIn
);
  dpStrobe_t strobe;
  logic      run;
  logic      tick;
  logic      txBit;

  swreg_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk  (clk),
    .rstN (rstN),
    .run  (run),
    .tick (tick)
  );

  swreg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .tick     (tick),
    .txBit    (txBit),
    .run      (run),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .csOut    (csOut),
    .csOe     (csOe),
    .sclkOut  (sclkOut),
    .sclkOe   (sclkOe),
    .sdOut    (sdOut),
    .sdOe     (sdOe)
  );

  swreg_dpath u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqWrite (reqWrite),
    .reqTable (reqTable),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .sdIn     (sdIn),
    .txBit    (txBit),
    .result   (result)
  );
endmodule

// File: tb/swreg_serial_master_bench.sv
module swreg_serial_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int NVEC       = 8;

  // {write, table, addr[7:0], wdata[15:0], replyWord[31:0]}
  localparam logic [57:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 8'h05, 16'h0000, 32'hA5C3_1E7F},
    {1'b0, 1'b0, 8'h12, 16'h0000, 32'h1234_BEEF},
    {1'b0, 1'b1, 8'h3C, 16'h0000, 32'hDEAD_0001},
    {1'b0, 1'b1, 8'h7F, 16'h0000, 32'h8000_0001},
    {1'b1, 1'b0, 8'h11, 16'hFF30, 32'h0000_0000},
    {1'b1, 1'b0, 8'hA5, 16'h0001, 32'h0000_0000},
    {1'b0, 1'b0, 8'h00, 16'h0000, 32'hFFFF_0000},
    {1'b0, 1'b0, 8'hFF, 16'h0000, 32'h0F0F_F0F0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqTable = 1'b0;
  logic [7:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic busy, done, csOut, csOe, sclkOut, sclkOe, sdOut, sdOe;
  logic [31:0] result;
  logic sdIn = 1'b0;

  int checks = 0;
  int failures = 0;

  // device model state
  logic [31:0] slaveWord = '0;
  logic        curWrite = 1'b0;
  logic [63:0] frameCap = '0;
  int edgeTot = 0, sentTot = 0, quietTot = 0, postCnt = 0;
  int csHighTot = 0, doneTot = 0, err6 = 0, err7 = 0;
  logic prevSclk = 1'b0, prevSd = 1'b0, prevOe = 1'b0;
  int runLen = 0, sdSince = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  swreg_serial_master #(.HALF_CYCLES(HALF)) u_swreg_serial_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqTable(reqTable), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .done(done), .result(result),
    .csOut(csOut), .csOe(csOe), .sclkOut(sclkOut), .sclkOe(sclkOe),
    .sdOut(sdOut), .sdOe(sdOe), .sdIn(sdIn)
  );

  // device side: capture command bits, serve the reply
  always @(posedge sclkOut) begin
    edgeTot++;
    if (sdOe && (csOut || !curWrite)) begin
      frameCap = {frameCap[62:0], sdOut};
      sentTot++;
    end
    if (sdOe) postCnt = 0;
    else begin
      quietTot++;
      postCnt++;
      if (postCnt >= 2 && postCnt <= 33) sdIn = slaveWord[33 - postCnt];
      else sdIn = 1'b0;
    end
  end

  // line timing monitor (R6, R7)
  always @(negedge clk) begin
    if (done) doneTot++;
    if (csOut) csHighTot++;
    if (sdOut != prevSd) begin
      sdSince = 0;
      if (sdOe && sclkOut) err6++;
    end else sdSince++;
    if (sclkOut != prevSclk) begin
      if (prevOe && sclkOe && runLen < HALF) err7++;
      if (sclkOut && sdOe && sdSince < HALF) err6++;
      runLen = 1;
    end else runLen++;
    prevSclk = sclkOut;
    prevSd   = sdOut;
    prevOe   = sclkOe;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic runVec(input logic [57:0] v);
    logic wr, tbl;
    logic [7:0] addr;
    logic [15:0] wd;
    logic [31:0] word, expRes;
    logic [45:0] expRd;
    logic [26:0] expWr;
    int e0, s0, q0, c0, d0, r6, r7;
    wr = v[57]; tbl = v[56]; addr = v[55:48]; wd = v[47:32]; word = v[31:0];
    e0 = edgeTot; s0 = sentTot; q0 = quietTot; c0 = csHighTot; d0 = doneTot;
    r6 = err6; r7 = err7;
    @(negedge clk);
    slaveWord = word; curWrite = wr;
    reqWrite = wr; reqTable = tbl; reqAddr = addr; reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(busy == 1'b1, "R11", "busy after accept", 64'(busy), 64'd1);
    waitDone();
    chk(done && !busy, "R12", "done with busy low", {62'd0, done, busy}, 64'd2);
    if (wr) expRes = '0;
    else if (tbl) expRes = word;
    else if (addr[0]) expRes = {16'd0, word[31:16]};
    else expRes = {16'd0, word[15:0]};
    if (wr) begin
      expWr = {1'b1, 2'b01, addr, wd};
      chk(frameCap[26:0] == expWr && sentTot - s0 == 27, "R4", "write frame",
          {frameCap[31:0], 32'(sentTot - s0)}, {5'd0, expWr, 32'd27});
      chk(edgeTot - e0 == 29 && !csOut, "R5", "write clocks, cs low at end",
          64'(edgeTot - e0), 64'd29);
      chk(result == 32'd0, "R10", "write result", 64'(result), 64'd0);
    end else begin
      expRd = {32'hFFFF_FFFF, 4'b0110, tbl, 2'b00, addr[6:0]};
      chk(frameCap[45:0] == expRd && sentTot - s0 == 46, "R1", "read frame",
          {18'd0, frameCap[45:0]}, {18'd0, expRd});
      chk(csHighTot == c0, "R2", "cs during read", 64'(csHighTot - c0), 64'd0);
      chk(edgeTot - e0 == 82 && quietTot - q0 == 36, "R3", "read edges/released edges",
          {32'(edgeTot - e0), 32'(quietTot - q0)}, {32'd82, 32'd36});
      chk(result == expRes, tbl ? "R9" : "R8", "read result", 64'(result), 64'(expRes));
    end
    chk(err6 == r6, "R6", "data timing errors", 64'(err6 - r6), 64'd0);
    chk(err7 == r7, "R7", "short clock levels", 64'(err7 - r7), 64'd0);
    @(negedge clk);
    chk(!done && doneTot - d0 == 1, "R12", "single done pulse", 64'(doneTot - d0), 64'd1);
    @(negedge clk);
    chk(!csOe && !sclkOe && !sdOe, "R13", "lines released after done",
        {61'd0, csOe, sclkOe, sdOe}, 64'd0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int d0, s0;
    logic [31:0] resBefore;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && result == 0, "R13", "reset outputs",
        {30'd0, busy, done, result}, 64'd0);
    chk(!csOe && !sclkOe && !sdOe, "R13", "reset enables",
        {61'd0, csOe, sclkOe, sdOe}, 64'd0);

    for (int i = 0; i < NVEC; i++) runVec(VECS[i]);

    // R11: a request during a running write is ignored; R12: result held meanwhile
    d0 = doneTot; s0 = sentTot;
    resBefore = result;
    @(negedge clk);
    curWrite = 1'b1;
    reqWrite = 1'b1; reqTable = 1'b0; reqAddr = 8'h01; reqWdata = 16'h1234; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (30) @(negedge clk);
    reqWrite = 1'b0; reqTable = 1'b1; reqAddr = 8'h33; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(result == resBefore, "R12", "result held mid-transaction", 64'(result), 64'(resBefore));
    waitDone();
    chk(frameCap[26:0] == {1'b1, 2'b01, 8'h01, 16'h1234} && sentTot - s0 == 27, "R11",
        "frame of first request kept", {32'd0, 5'd0, frameCap[26:0]},
        {37'd0, 1'b1, 2'b01, 8'h01, 16'h1234});
    repeat (20) @(negedge clk);
    chk(!busy && doneTot - d0 == 1, "R11", "ignored request never ran",
        {31'd0, busy, 32'(doneTot - d0)}, 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule